// File: doc/BRIEF.md
# Dual-Port Double-Rate Burst SRAM

This block is a cycle-accurate, synthesizable behavioural model of a synchronous static RAM. It has a dedicated read data port and a dedicated write data port, and both ports share one address bus. The complementary input clock pair is modelled as the two edges of a single clock `clk`. The rising edge stands for the primary clock and the falling edge for its complement. Every location stores a pair of 18-bit words. These words move as a two-beat burst, one beat per clock edge, so each port can complete one burst in every clock period.

A read command is taken on a rising edge, and the address bus carries the read address at that edge. On the falling edge that follows, the same bus carries the write address. Each write beat has its own two active-low byte enables. Writes are held in a one-entry buffer and reach the array at a later falling edge. A read that collides with a write that has not yet committed gets the write data forwarded to it. The forwarding applies the byte masks, so a masked byte still comes from the array. The read and write engines run concurrently. Each engine is a small two-state command machine: read RD_IDLE/RD_REQ, write WR_IDLE/WR_REQ. The write engine also has a buffer machine with states BUF_EMPTY/BUF_HALF. For each of these machines, a request sampled at a rising edge moves it to the busy state, and no request moves it back to idle. BUF_HALF is entered at a falling edge that captures a write address, and it is left at the next falling edge that commits the buffer without reloading it.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first read, `rvalid` is 0, `rdata_oe_n` is 1 and `rdata` is 0.
- R2: When `rd_n` is low at rising edge n, `addr` at that edge is the read address. Word 0 is on `rdata` while `clk` is high after rising edge n+1. Word 1 is on `rdata` while `clk` is low after the following falling edge. `rvalid` is 1 for that whole clock cycle.
- R3: When `rd_n` is high at rising edge n, then throughout the cycle after rising edge n+1, `rdata_oe_n` is 1 (outputs high impedance), `rvalid` is 0 and `rdata` is 0.
- R4: When `wr_n` is low at rising edge n, the next falling edge samples three things: the write address from `addr`, word 0 from `wdata` and beat-0 enables from `bw_n`. Rising edge n+1 then samples word 1 from `wdata` and the beat-1 enables from `bw_n`.
- R5: `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9. An enable that is high leaves that byte unchanged. The enables of the two beats are independent.
- R6: A write requested at rising edge n is visible to any read requested at rising edge n+1 or later.
- R7: A read requested at the same rising edge as a write to the same address returns the write data, byte by byte, for every enabled byte. Every masked byte returns the array contents.
- R8: Reads and writes can each be requested at every rising edge. Back-to-back reads keep `rvalid` high and return each burst in order.
- R9: A read requested together with a write to a different address returns that location's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge = primary, falling edge = complement |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| rd_n | input | 1 | Active-low read request, sampled at rising edge |
| wr_n | input | 1 | Active-low write request, sampled at rising edge |
| addr | input | ADDR_W | Read address at rising edge, write address at falling edge |
| bw_n | input | 2 | Active-low byte enables, sampled for each write beat |
| wdata | input | 18 | Write data, beat 0 at falling edge, beat 1 at rising edge |
| rdata | output | 18 | Read data, beat 0 in high phase, beat 1 in low phase |
| rvalid | output | 1 | Read data valid for the current clock cycle |
| rdata_oe_n | output | 1 | 1 = read data outputs high impedance |

## Verification
Read results for a request at rising edge n are due one cycle later. Word 0 is sampled 2 ns after rising edge n+1, while `clk` is still high. Word 1 is sampled 2 ns after the falling edge that follows, while `clk` is low. The bench keeps a two-deep pipeline of expected results so that every slot is compared with the request that produced it. Write data is driven as R4 requires: address and word 0 after the rising edge, word 1 after the falling edge. The bench applies each write to its reference memory before it computes the result of a read issued at the same edge, so same-address collisions and next-cycle reads are predicted from the requirements alone.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int BYTE_W = 9;
    localparam int NBYTES = 2;
    localparam int WORD_W = BYTE_W * NBYTES;

    typedef enum logic {WR_IDLE, WR_REQ} wr_cmd_e;
    typedef enum logic {BUF_EMPTY, BUF_HALF} wr_buf_e;
    typedef enum logic {RD_IDLE, RD_REQ} rd_cmd_e;

    // Replace enabled bytes (mask bit low) of old_w with new_w.
    function automatic logic [WORD_W-1:0] byte_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [NBYTES-1:0] mask_n
    );
        logic [WORD_W-1:0] res;
        for (int b = 0; b < NBYTES; b++) begin
            res[b*BYTE_W +: BYTE_W] = mask_n[b] ? old_w[b*BYTE_W +: BYTE_W]
                                                : new_w[b*BYTE_W +: BYTE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/bsr_array.sv
module bsr_array
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wd0,
    input  logic [WORD_W-1:0] wd1,
    input  logic [NBYTES-1:0] wm0_n,
    input  logic [NBYTES-1:0] wm1_n,
    input  logic [ADDR_W-1:0] raddr0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [WORD_W-1:0] rd0,
    output logic [WORD_W-1:0] rd1
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage lane per byte and per burst word.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane0 [DEPTH];
        logic [BYTE_W-1:0] lane1 [DEPTH];

        always_ff @(negedge clk) begin
            if (we && !wm0_n[b]) lane0[waddr] <= wd0[b*BYTE_W +: BYTE_W];
            if (we && !wm1_n[b]) lane1[waddr] <= wd1[b*BYTE_W +: BYTE_W];
        end

        assign rd0[b*BYTE_W +: BYTE_W] = lane0[raddr0];
        assign rd1[b*BYTE_W +: BYTE_W] = lane1[raddr1];
    end

endmodule

// File: rtl/bsr_wr_engine.sv
module bsr_wr_engine
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] bw_n,
    input  logic [WORD_W-1:0] wdata,
    output logic              buf_half,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [WORD_W-1:0] buf_d0,
    output logic [WORD_W-1:0] buf_d1,
    output logic [NBYTES-1:0] buf_m0_n,
    output logic [NBYTES-1:0] buf_m1_n
);

    wr_cmd_e cmd_q, cmd_d;
    wr_buf_e buf_q, buf_d;

    always_comb begin
        unique case (cmd_q)
            WR_IDLE: cmd_d = wr_n ? WR_IDLE : WR_REQ;
            WR_REQ:  cmd_d = wr_n ? WR_IDLE : WR_REQ;
            default: cmd_d = WR_IDLE;
        endcase
    end

    // A captured write commits at the next falling edge; a new one may load at that same edge.
    always_comb begin
        unique case (buf_q)
            BUF_EMPTY: buf_d = (cmd_q == WR_REQ) ? BUF_HALF : BUF_EMPTY;
            BUF_HALF:  buf_d = (cmd_q == WR_REQ) ? BUF_HALF : BUF_EMPTY;
            default:   buf_d = BUF_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= WR_IDLE;
        else        cmd_q <= cmd_d;
    end

    // Address and beat 0 on the complementary edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q    <= BUF_EMPTY;
            buf_addr <= '0;
            buf_d0   <= '0;
            buf_m0_n <= '1;
        end else begin
            buf_q <= buf_d;
            if (cmd_q == WR_REQ) begin
                buf_addr <= addr;
                buf_d0   <= wdata;
                buf_m0_n <= bw_n;
            end
        end
    end

    // Beat 1 on the following primary edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_d1   <= '0;
            buf_m1_n <= '1;
        end else if (buf_q == BUF_HALF) begin
            buf_d1   <= wdata;
            buf_m1_n <= bw_n;
        end
    end

    assign buf_half = (buf_q == BUF_HALF);

    AST_WR_CAPTURES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> buf_half) else $error("write request not captured"); // R4
    AST_WR_BUFFER_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n |=> !buf_half) else $error("write buffer held without request"); // R6

endmodule

// File: rtl/bsr_rd_engine.sv
module bsr_rd_engine
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              buf_half,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [WORD_W-1:0] buf_d0,
    input  logic [WORD_W-1:0] buf_d1,
    input  logic [NBYTES-1:0] buf_m0_n,
    input  logic [NBYTES-1:0] buf_m1_n,
    input  logic [WORD_W-1:0] arr_rd0,
    input  logic [WORD_W-1:0] arr_rd1,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [WORD_W-1:0] q_rise,
    output logic [WORD_W-1:0] q_fall,
    output logic              v_rise,
    output logic              v_fall
);

    rd_cmd_e cmd_q, cmd_d;
    logic [WORD_W-1:0] word0, word1;
    logic hit0, hit1;

    always_comb begin
        unique case (cmd_q)
            RD_IDLE: cmd_d = rd_n ? RD_IDLE : RD_REQ;
            RD_REQ:  cmd_d = rd_n ? RD_IDLE : RD_REQ;
            default: cmd_d = RD_IDLE;
        endcase
    end

    // The buffered write is the one requested alongside this read.
    assign hit0  = buf_half && (buf_addr == cur_addr);
    assign hit1  = buf_half && (buf_addr == hold_addr);
    assign word0 = hit0 ? byte_merge(arr_rd0, buf_d0, buf_m0_n) : arr_rd0;
    assign word1 = hit1 ? byte_merge(arr_rd1, buf_d1, buf_m1_n) : arr_rd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= RD_IDLE;
            cur_addr  <= '0;
            hold_addr <= '0;
            v_rise    <= 1'b0;
            q_rise    <= '0;
        end else begin
            cmd_q     <= cmd_d;
            hold_addr <= cur_addr;
            if (!rd_n) cur_addr <= addr;
            v_rise    <= (cmd_q == RD_REQ);
            q_rise    <= (cmd_q == RD_REQ) ? word0 : '0;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_fall <= 1'b0;
            q_fall <= '0;
        end else begin
            v_fall <= v_rise;
            q_fall <= v_rise ? word1 : '0;
        end
    end

    AST_BEAT1_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        v_rise |-> v_fall) else $error("beat 1 missing"); // R2

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bw_n,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic              rvalid,
    output logic              rdata_oe_n
);

    logic              buf_half;
    logic [ADDR_W-1:0] buf_addr, cur_addr, hold_addr;
    logic [WORD_W-1:0] buf_d0, buf_d1, arr_rd0, arr_rd1, q_rise, q_fall;
    logic [NBYTES-1:0] buf_m0_n, buf_m1_n;
    logic              v_rise, v_fall;

    bsr_wr_engine #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .bw_n(bw_n),
        .wdata(wdata), .buf_half(buf_half), .buf_addr(buf_addr),
        .buf_d0(buf_d0), .buf_d1(buf_d1), .buf_m0_n(buf_m0_n), .buf_m1_n(buf_m1_n)
    );

    bsr_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we(buf_half), .waddr(buf_addr), .wd0(buf_d0), .wd1(buf_d1),
        .wm0_n(buf_m0_n), .wm1_n(buf_m1_n), .raddr0(cur_addr), .raddr1(hold_addr),
        .rd0(arr_rd0), .rd1(arr_rd1)
    );

    bsr_rd_engine #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .addr(addr),
        .buf_half(buf_half), .buf_addr(buf_addr), .buf_d0(buf_d0), .buf_d1(buf_d1),
        .buf_m0_n(buf_m0_n), .buf_m1_n(buf_m1_n), .arr_rd0(arr_rd0), .arr_rd1(arr_rd1),
        .cur_addr(cur_addr), .hold_addr(hold_addr), .q_rise(q_rise), .q_fall(q_fall),
        .v_rise(v_rise), .v_fall(v_fall)
    );

    assign rdata      = clk ? q_rise : q_fall;
    assign rvalid     = v_rise;
    assign rdata_oe_n = !v_rise;

    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> ##2 rvalid) else $error("read data not returned"); // R2
    AST_IDLE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> ##2 rdata_oe_n) else $error("outputs driven after idle"); // R3

endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1, wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    bw_n = 2'b11;
    logic [17:0]   wdata = '0;
    logic [17:0]   rdata;
    logic          rvalid, rdata_oe_n;

    always #4 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .rdata_oe_n(rdata_oe_n)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    logic [17:0] mdl0 [DEPTH];
    logic [17:0] mdl1 [DEPTH];

    typedef struct packed { logic v; logic [17:0] w0; logic [17:0] w1; } exp_t;
    exp_t e1 = '0, e2 = '0;
    string t1 = "R3", t2 = "R3";
    logic [17:0] pend_d1 = '0;
    logic [1:0]  pend_m1 = 2'b11;

    function automatic logic [17:0] merge(input logic [17:0] o, input logic [17:0] n,
                                          input logic [1:0] m);
        merge = o;
        if (!m[0]) merge[8:0]  = n[8:0];
        if (!m[1]) merge[17:9] = n[17:9];
    endfunction

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {rvalid,oe_n,rdata} got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_slot(input exp_t e, input bit beat1, input string tag);
        if (e.v) check(tag, {rvalid, rdata_oe_n, rdata}, {2'b10, beat1 ? e.w1 : e.w0});
        else     check("R3", {rvalid, rdata_oe_n, rdata}, {2'b01, 18'd0});
    endtask

    // One clock cycle: commands at rising edge n, write address/beat 0 at the falling edge.
    task automatic step(input bit rd, input logic [AW-1:0] ra, input bit wr,
                        input logic [AW-1:0] wa, input logic [17:0] d0, input logic [17:0] d1,
                        input logic [1:0] k0, input logic [1:0] k1, input string tag);
        exp_t e;
        string tg;
        @(negedge clk); #2;
        check_slot(e2, 1'b1, t2);                     // R2 beat 1 of read n-2
        rd_n = !rd; wr_n = !wr; addr = ra; wdata = pend_d1; bw_n = pend_m1;
        if (wr) begin
            mdl0[wa] = merge(mdl0[wa], d0, k0);
            mdl1[wa] = merge(mdl1[wa], d1, k1);
        end
        e.v = rd; e.w0 = mdl0[ra]; e.w1 = mdl1[ra];
        tg = tag;
        if (tg == "") tg = (rd && wr && ra == wa) ? "R7" : "R2";
        @(posedge clk); #2;
        check_slot(e1, 1'b0, t1);                     // R2 beat 0 of read n-1
        addr = wa; wdata = d0; bw_n = k0;             // R4 sampled at falling edge
        pend_d1 = d1; pend_m1 = wr ? k1 : 2'b11;
        e2 = e1; t2 = t1; e1 = e; t1 = tg;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, '0, 2'b11, 2'b11, "R3");
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin mdl0[i] = '0; mdl1[i] = '0; end
        repeat (3) @(posedge clk);
        #2;
        check("R1", {rvalid, rdata_oe_n, rdata}, {2'b01, 18'd0});
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1", {rvalid, rdata_oe_n, rdata}, {2'b01, 18'd0});

        // Fill every location with full-mask writes, back to back.
        for (int a = 0; a < DEPTH; a++)
            step(0, '0, 1, AW'(a), 18'(a * 7 + 1), 18'(a * 13 + 5), 2'b00, 2'b00, "R4");
        idle(2);
        // R8: back-to-back reads over the whole array.
        for (int a = 0; a < DEPTH; a++) step(1, AW'(a), 0, '0, '0, '0, 2'b11, 2'b11, "R8");
        idle(2);
        // R6: write then read on the very next rising edge.
        step(0, '0, 1, 4'd5, 18'h2AAAA, 18'h15555, 2'b00, 2'b00, "R4");
        step(1, 4'd5, 0, '0, '0, '0, 2'b11, 2'b11, "R6");
        // R7: same-edge collision with different masks per beat.
        step(1, 4'd3, 1, 4'd3, 18'h3FFFF, 18'h3FFFF, 2'b01, 2'b10, "R7");
        // R9: same-edge read of a different address.
        step(1, 4'd6, 1, 4'd4, 18'h12345, 18'h0ABCD, 2'b00, 2'b00, "R9");
        // R5: beat 0 fully masked, beat 1 upper byte only.
        step(0, '0, 1, 4'd7, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b01, "R5");
        idle(1);
        step(1, 4'd7, 0, '0, '0, '0, 2'b11, 2'b11, "R5");
        step(1, 4'd4, 0, '0, '0, '0, 2'b11, 2'b11, "R9");
        idle(3);
        // Random mix at full rate on both ports.
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) != 0, AW'($urandom), $urandom_range(0, 2) != 0,
                 AW'($urandom_range(0, 3)), 18'($urandom), 18'($urandom),
                 2'($urandom), 2'($urandom), "");
        end
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule